// File: doc/BRIEF.md
# Timer Compare Unit with Event Trigger

This block watches the running count of one of two 16-bit timers and compares it, every clock, with a programmable 16-bit compare value. When the selected count becomes equal to the compare value, the block carries out the action chosen by a 4-bit mode field. It can set, clear or toggle a latched output pin. It can raise only an interrupt flag. It can also fire a hardware trigger that restarts the selected timer and, if the converter is enabled, requests a conversion. In trigger mode the compare value acts as a programmable period for that timer.

Software programs the block through a small write port with two locations. Location 0 holds the compare value. Location 1 holds the mode, the timer select and the pin output enable. Both timer counts arrive from timers that share the block's clock. A match counts once per rising edge of equality, so a count that stays on the compare value for several cycles causes a single action.

Top module: `tcmp_top`

## Requirements
- R1: While reset is held and after it is released, every output is low: pin_out, pin_oe, irq_flag, tmr_a_rst, tmr_b_rst and conv_start.
- R2: Writing with reg_addr=1 sets mode=reg_wdata[3:0], timer select=reg_wdata[4] (0 picks tmr_a_cnt, 1 picks tmr_b_cnt) and output enable=reg_wdata[5]. Only the selected count is compared. Equality on the other count has no effect.
- R3: The match action takes effect on the clock edge that ends the first cycle of equality and is visible one cycle later. Mode 1000 drives the pin latch high, mode 1001 drives it low and mode 0010 inverts it.
- R4: In mode 1010 (interrupt only), a match sets irq_flag and leaves the pin latch unchanged.
- R5: A match in any of the modes 1000, 1001, 0010, 1010 or 1011 sets irq_flag. flag_clr clears the flag on the next edge. A match in the same cycle as flag_clr leaves the flag set.
- R6: A count that stays equal to the compare value for several cycles produces only one action. The next action needs the equality to end and then return.
- R7: In mode 1011, a match produces a one-cycle pulse on the reset output of the selected timer only (tmr_a_rst for select 0, tmr_b_rst for select 1), sets irq_flag, and leaves the pin latch unchanged.
- R8: conv_start pulses for one cycle together with the trigger reset pulse when conv_en was high in the matching cycle. It stays low otherwise.
- R9: A control write with mode 0000 forces the pin latch low on the next edge. Codes not listed in R3–R7 take no match action and leave the latch as it is.
- R10: pin_oe follows the output-enable bit. While it is 0, pin_out is low but the latch keeps its value. That value reappears on pin_out once the output is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, shared with both timers |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0: compare value, 1: control |
| reg_wdata | input | 16 | Write data |
| tmr_a_cnt | input | 16 | Count of timer A |
| tmr_b_cnt | input | 16 | Count of timer B |
| flag_clr | input | 1 | Clears irq_flag |
| conv_en | input | 1 | Converter enabled; gates conv_start |
| pin_out | output | 1 | Compare output pin value |
| pin_oe | output | 1 | Pin output enable |
| irq_flag | output | 1 | Compare interrupt flag |
| tmr_a_rst | output | 1 | One-cycle reset request to timer A |
| tmr_b_rst | output | 1 | One-cycle reset request to timer B |
| conv_start | output | 1 | One-cycle conversion start request |

## Verification
The hardest case to reach from the ports is a match that lands in the same cycle as another event. Examples are a flag clear, a control write that zeroes the mode, and equality that is already present when the mode is switched on. The stimulus holds a timer count on the compare value across a flag clear and across mode changes. It lines up the final approach of the count with the clear strobe. It also moves the count on the unselected timer through the compare value while the selected one stays away. A behavioural model in the bench tracks the previous equality on its own, so a missed or repeated action shows up on the very next cycle.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;
  localparam int unsigned MODE_W = 4;
  localparam int unsigned NUM_TMR = 2;

  localparam logic [MODE_W-1:0] MD_OFF  = 4'b0000;
  localparam logic [MODE_W-1:0] MD_SET  = 4'b1000;
  localparam logic [MODE_W-1:0] MD_CLR  = 4'b1001;
  localparam logic [MODE_W-1:0] MD_TGL  = 4'b0010;
  localparam logic [MODE_W-1:0] MD_IRQ  = 4'b1010;
  localparam logic [MODE_W-1:0] MD_TRIG = 4'b1011;

  typedef struct packed {
    logic              oe;
    logic              tsel;
    logic [MODE_W-1:0] mode;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/tcmp_cfg.sv
module tcmp_cfg
  import tcmp_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cmp_val,
  output ctrl_t            ctrl,
  output logic             off_wr
);
  logic [CNT_W-1:0] cmp_d, cmp_q;
  ctrl_t            ctrl_d, ctrl_q;
  logic             cmp_en, ctrl_en;

  always_comb begin
    cmp_en  = we && !addr;
    ctrl_en = we && addr;
    cmp_d   = wdata;
    ctrl_d  = ctrl_t'(wdata[CTRL_W-1:0]);
    off_wr  = ctrl_en && (ctrl_d.mode == MD_OFF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      ctrl_q <= '0;
    end else begin
      if (cmp_en)  cmp_q  <= cmp_d;
      if (ctrl_en) ctrl_q <= ctrl_d;
    end
  end

  assign cmp_val = cmp_q;
  assign ctrl    = ctrl_q;
endmodule

// File: rtl/tcmp_match.sv
module tcmp_match
  import tcmp_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_TMR-1:0][CNT_W-1:0]  cnt_all,
  input  logic                           tsel,
  input  logic [CNT_W-1:0]               cmp_val,
  output logic                           hit
);
  logic [CNT_W-1:0] cnt_sel;
  logic             eq, eq_q;

  always_comb begin
    cnt_sel = cnt_all[tsel];
    eq      = (cnt_sel == cmp_val);
    hit     = eq && !eq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eq_q <= 1'b0;
    else        eq_q <= eq;
  end
endmodule

// File: rtl/tcmp_action.sv
module tcmp_action
  import tcmp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hit,
  input  ctrl_t              ctrl,
  input  logic               off_wr,
  input  logic               flag_clr,
  input  logic               conv_en,
  output logic               latch,
  output logic               flag,
  output logic [NUM_TMR-1:0] tmr_rst,
  output logic               conv
);
  logic               latch_d, latch_q;
  logic               flag_d, flag_q;
  logic               trig_d;
  logic [NUM_TMR-1:0] rst_d, rst_q;
  logic               conv_d, conv_q;
  logic               act;

  always_comb begin
    act = 1'b0;
    case (ctrl.mode)
      MD_SET, MD_CLR, MD_TGL, MD_IRQ, MD_TRIG: act = hit;
      default:                                 act = 1'b0;
    endcase

    latch_d = latch_q;
    if (off_wr) latch_d = 1'b0;
    else if (hit) begin
      case (ctrl.mode)
        MD_SET:  latch_d = 1'b1;
        MD_CLR:  latch_d = 1'b0;
        MD_TGL:  latch_d = !latch_q;
        default: latch_d = latch_q;
      endcase
    end

    if (act)           flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
    else               flag_d = flag_q;

    trig_d = hit && (ctrl.mode == MD_TRIG);
    conv_d = trig_d && conv_en;
  end

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_rst
    assign rst_d[i] = trig_d && (int'(ctrl.tsel) == i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
      flag_q  <= 1'b0;
      rst_q   <= '0;
      conv_q  <= 1'b0;
    end else begin
      latch_q <= latch_d;
      flag_q  <= flag_d;
      rst_q   <= rst_d;
      conv_q  <= conv_d;
    end
  end

  assign latch   = latch_q;
  assign flag    = flag_q;
  assign tmr_rst = rst_q;
  assign conv    = conv_q;
endmodule

// File: rtl/tcmp_top.sv
module tcmp_top
  import tcmp_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic             reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  input  logic [CNT_W-1:0] tmr_a_cnt,
  input  logic [CNT_W-1:0] tmr_b_cnt,
  input  logic             flag_clr,
  input  logic             conv_en,
  output logic             pin_out,
  output logic             pin_oe,
  output logic             irq_flag,
  output logic             tmr_a_rst,
  output logic             tmr_b_rst,
  output logic             conv_start
);
  logic [CNT_W-1:0]              cmp_val;
  ctrl_t                         ctrl;
  logic                          off_wr;
  logic                          hit;
  logic                          latch;
  logic [NUM_TMR-1:0]            tmr_rst;
  logic [NUM_TMR-1:0][CNT_W-1:0] cnt_all;

  assign cnt_all[0] = tmr_a_cnt;
  assign cnt_all[1] = tmr_b_cnt;

  tcmp_cfg #(.CNT_W(CNT_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .cmp_val(cmp_val), .ctrl(ctrl), .off_wr(off_wr)
  );

  tcmp_match #(.CNT_W(CNT_W)) match_i (
    .clk(clk), .rst_n(rst_n), .cnt_all(cnt_all), .tsel(ctrl.tsel),
    .cmp_val(cmp_val), .hit(hit)
  );

  tcmp_action action_i (
    .clk(clk), .rst_n(rst_n), .hit(hit), .ctrl(ctrl), .off_wr(off_wr),
    .flag_clr(flag_clr), .conv_en(conv_en), .latch(latch), .flag(irq_flag),
    .tmr_rst(tmr_rst), .conv(conv_start)
  );

  assign pin_oe    = ctrl.oe;
  assign pin_out   = ctrl.oe && latch;
  assign tmr_a_rst = tmr_rst[0];
  assign tmr_b_rst = tmr_rst[1];
endmodule

// File: rtl/tcmp_chk.sv
module tcmp_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic             reg_addr,
  input logic [CNT_W-1:0] reg_wdata,
  input logic [CNT_W-1:0] tmr_a_cnt,
  input logic [CNT_W-1:0] tmr_b_cnt,
  input logic             flag_clr,
  input logic             conv_en,
  input logic             pin_out,
  input logic             pin_oe,
  input logic             irq_flag,
  input logic             tmr_a_rst,
  input logic             tmr_b_rst,
  input logic             conv_start
);
  assert_rst_a_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_a_rst |=> !tmr_a_rst);
  assert_rst_b_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_b_rst |=> !tmr_b_rst);
  assert_rst_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tmr_a_rst, tmr_b_rst}));
  assert_trig_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_a_rst || tmr_b_rst) |-> irq_flag);
  assert_conv_with_trig_R8: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (tmr_a_rst || tmr_b_rst));
  assert_off_forces_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr && reg_wdata[3:0] == 4'b0000) |=> !pin_out);
endmodule

bind tcmp_top tcmp_chk #(.CNT_W(CNT_W)) chk_i (.*);

// File: tb/tcmp_top_tb_top.sv
module tcmp_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic        reg_addr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] tmr_a_cnt = '0;
  logic [15:0] tmr_b_cnt = '0;
  logic        flag_clr = 1'b0;
  logic        conv_en = 1'b0;
  logic        pin_out, pin_oe, irq_flag, tmr_a_rst, tmr_b_rst, conv_start;

  int n_chk = 0;
  int n_fail = 0;
  int cyc_cnt = 0;

  // behavioural reference state
  bit [15:0] m_cmp;
  bit [3:0]  m_mode;
  bit        m_tsel, m_oe, m_latch, m_flag, m_eqp, m_ra, m_rb, m_conv;

  always #10 clk = ~clk;

  tcmp_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .tmr_a_cnt(tmr_a_cnt), .tmr_b_cnt(tmr_b_cnt),
    .flag_clr(flag_clr), .conv_en(conv_en), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq_flag(irq_flag), .tmr_a_rst(tmr_a_rst), .tmr_b_rst(tmr_b_rst),
    .conv_start(conv_start)
  );

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual=%b expected=%b", tag, cyc_cnt, act, exp);
    end
  endtask

  // model update at each active edge, reading pre-edge state
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cmp = 0; m_mode = 0; m_tsel = 0; m_oe = 0; m_latch = 0;
      m_flag = 0; m_eqp = 0; m_ra = 0; m_rb = 0; m_conv = 0;
    end else begin
      bit eq, hit, act, trig;
      eq   = ((m_tsel ? tmr_b_cnt : tmr_a_cnt) == m_cmp);
      hit  = eq && !m_eqp;
      m_eqp = eq;
      act  = hit && (m_mode == 4'b1000 || m_mode == 4'b1001 || m_mode == 4'b0010 ||
                     m_mode == 4'b1010 || m_mode == 4'b1011);
      trig = hit && (m_mode == 4'b1011);
      m_ra = trig && !m_tsel;
      m_rb = trig && m_tsel;
      m_conv = trig && conv_en;
      if (act) m_flag = 1;
      else if (flag_clr) m_flag = 0;
      if (reg_we && reg_addr && reg_wdata[3:0] == 4'b0000) m_latch = 0;
      else if (hit) begin
        if (m_mode == 4'b1000) m_latch = 1;
        else if (m_mode == 4'b1001) m_latch = 0;
        else if (m_mode == 4'b0010) m_latch = !m_latch;
      end
      if (reg_we && !reg_addr) m_cmp = reg_wdata;
      if (reg_we && reg_addr) begin
        m_mode = reg_wdata[3:0];
        m_tsel = reg_wdata[4];
        m_oe   = reg_wdata[5];
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    cyc_cnt++;
    if (rst_n) begin
      chk("R3 pin_out", pin_out, m_oe && m_latch);
      chk("R10 pin_oe", pin_oe, m_oe);
      chk("R5 irq_flag", irq_flag, m_flag);
      chk("R7 tmr_a_rst", tmr_a_rst, m_ra);
      chk("R7 tmr_b_rst", tmr_b_rst, m_rb);
      chk("R8 conv_start", conv_start, m_conv);
    end
    if (cyc_cnt > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
      $finish;
    end
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic a, logic [15:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    step();
    reg_we = 0;
  endtask

  function automatic logic [15:0] ctl(logic oe, logic ts, logic [3:0] md);
    return {10'd0, oe, ts, md};
  endfunction

  // move the selected-style count through the compare point
  task automatic sweep_a(int from, int to);
    for (int v = from; v <= to; v++) begin tmr_a_cnt = 16'(v); step(); end
  endtask
  task automatic sweep_b(int from, int to);
    for (int v = from; v <= to; v++) begin tmr_b_cnt = 16'(v); step(); end
  endtask

  initial begin
    step(3);
    // R1: outputs during reset
    chk("R1 pin_out", pin_out, 0); chk("R1 irq_flag", irq_flag, 0);
    chk("R1 conv_start", conv_start, 0);
    rst_n = 1;
    step();
    chk("R1 pin_oe", pin_oe, 0); chk("R1 tmr_a_rst", tmr_a_rst, 0);
    chk("R1 tmr_b_rst", tmr_b_rst, 0);

    tmr_a_cnt = 16'd100; tmr_b_cnt = 16'd200;
    wr(0, 16'd5);
    wr(1, ctl(1, 0, 4'b1000));
    sweep_a(0, 5);
    chk("R3 set", pin_out, 1);
    chk("R5 flag set", irq_flag, 1);
    flag_clr = 1; step(); flag_clr = 0;
    chk("R5 clear", irq_flag, 0);
    step(4); // count held on compare value
    chk("R6 held no refire", irq_flag, 0);

    wr(1, ctl(1, 0, 4'b1001));
    chk("R6 equal at mode switch no action", pin_out, 1);
    sweep_a(6, 8); sweep_a(3, 5);
    chk("R3 clear", pin_out, 0);

    wr(1, ctl(1, 0, 4'b0010));
    sweep_a(6, 6); sweep_a(5, 5);
    chk("R3 toggle 1", pin_out, 1);
    sweep_a(6, 6); sweep_a(5, 5);
    chk("R3 toggle 2", pin_out, 0);

    // R2: select timer B; timer A equality ignored
    tmr_a_cnt = 0;
    wr(1, ctl(1, 1, 4'b0010));
    sweep_a(1, 7);
    chk("R2 unselected ignored", pin_out, 0);
    sweep_b(0, 5);
    chk("R2 selected toggles", pin_out, 1);

    // R4: interrupt only
    flag_clr = 1; step(); flag_clr = 0;
    wr(1, ctl(1, 1, 4'b1010));
    sweep_b(6, 6); sweep_b(5, 5);
    chk("R4 flag", irq_flag, 1);
    chk("R4 pin unchanged", pin_out, 1);

    // R5: match and clear in the same cycle
    tmr_b_cnt = 16'd9; step();
    flag_clr = 1; tmr_b_cnt = 16'd5; step(); flag_clr = 0;
    chk("R5 set wins over clear", irq_flag, 1);

    // R7/R8: trigger on timer B with converter enabled
    conv_en = 1;
    wr(1, ctl(1, 1, 4'b1011));
    tmr_b_cnt = 16'd2; step();
    tmr_b_cnt = 16'd5; step();
    chk("R7 b reset pulse", tmr_b_rst, 1);
    chk("R7 a quiet", tmr_a_rst, 0);
    chk("R8 conv pulse", conv_start, 1);
    tmr_b_cnt = 16'd0; step();
    chk("R7 pulse ends", tmr_b_rst, 0);
    chk("R7 pin unchanged", pin_out, 1);

    // R7/R8: trigger on timer A, converter disabled
    conv_en = 0; tmr_a_cnt = 0;
    wr(1, ctl(1, 0, 4'b1011));
    sweep_a(1, 5);
    chk("R7 a reset pulse", tmr_a_rst, 1);
    chk("R8 no conv when disabled", conv_start, 0);
    step();

    // R10: output enable off keeps latch
    wr(1, ctl(0, 0, 4'b1011));
    chk("R10 disabled low", pin_out, 0);
    chk("R10 oe low", pin_oe, 0);
    wr(1, ctl(1, 0, 4'b1011));
    chk("R10 latch restored", pin_out, 1);

    // R9: undefined code keeps latch, zero mode forces low
    wr(1, ctl(1, 0, 4'b0100));
    sweep_a(6, 6); sweep_a(5, 5);
    chk("R9 undefined keeps", pin_out, 1);
    wr(1, ctl(1, 0, 4'b0000));
    chk("R9 off forces low", pin_out, 0);

    step(3);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule